// File: doc/BRIEF.md
# Flag Pin Bank with Interrupt Logic

This block is a bank of general-purpose pins. Each pin can be an input or an output. Software changes output levels through two write-only strobes: a set register and a clear register. A one in a bit acts on that pin, and a zero leaves it alone. No read-modify-write is needed, so several agents can share the bank without racing each other. The interrupt enables work the same way, through their own pair of set and clear registers.

Each pin has its own sensitivity. It can be level (active high), rising edge only, or both edges. An input pin is judged on its pad value after a two-flop synchronizer. An output pin is judged on the value software wrote, so software can raise an interrupt on itself. An edge event is held in a sticky per-pin latch until software writes a one to that bit of the pending register. The single interrupt output is the OR of every pending pin whose enable is set.

The register bus is synchronous and word addressed. Writes take effect at the clock edge where `bus_sel` and `bus_we` are both high. Read data is combinational from the registered state.

Top module: `flagpin_bank`

## Requirements
- R1: After a synchronous reset, every register reads 0. `pad_oe`, `pad_out` and `irq` are all 0.
- R2: The direction register (word 0x0, read/write) drives `pad_oe` bit for bit (1 = output). `pad_out` carries the data register.
- R3: Writing word 0x2 sets every data bit that is written as 1 and leaves every bit written as 0 unchanged. Both word 0x2 and word 0x3 read back the data register.
- R4: Writing word 0x3 clears every data bit that is written as 1 and leaves every bit written as 0 unchanged.
- R5: Word 0x1 is read-only and returns the sense of every pin. For an input pin this is its pad value after two clock edges of synchronization. For an output pin it is its data bit.
- R6: Writing word 0x4 sets interrupt-enable bits and writing word 0x5 clears them, with ones acting and zeros ignored. Both words read the enable register.
- R7: A pin whose bit in the edge-select register (word 0x6) is 0 is level sensitive. Its pending bit in word 0x8 equals its sense, with no memory.
- R8: A pin with its edge-select bit set to 1 and its both-edges bit (word 0x7) set to 0 latches a pending bit on a 0-to-1 sense change only. The bit stays set until cleared.
- R9: A pin with edge-select 1 and both-edges 1 latches on either sense change.
- R10: Writing word 0x8 clears the edge latches whose bits are written as 1. If a new edge arrives in the same cycle as that clear, the clear wins.
- R11: `irq` is high exactly when some pin is both pending and enabled.
- R12: For an output pin, changing its pad input has no effect on its sense or its interrupt. Its edges come from the written data.
- R13: Unmapped words read 0 and ignore writes. Writes to word 0x1 are ignored. Register bits above the pin count read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational |
| pad_in | input | N | Pad input levels (asynchronous) |
| pad_out | output | N | Pad output levels |
| pad_oe | output | N | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench aims at a clear arriving in the same cycle as a new input edge. A design where the set path wins would leave a pending bit that software believes it has cleared. It checks that a falling pad edge on a rising-only pin leaves nothing latched; a design that ignored the mode would interrupt on both edges. It drives the pads of output pins and expects no change, which catches a sense mux that reads the pad regardless of direction. It samples the synchronizer one cycle too early to catch a chain that is too short. It also checks that zero bits in the set and clear strobes leave their neighbours untouched, which a plain register write would break.

// File: rtl/flagpin_pkg.sv
package flagpin_pkg;
   localparam int REG_AW = 4;

   typedef enum logic [REG_AW-1:0] {
      A_DIR   = 4'h0,
      A_SENSE = 4'h1,
      A_DSET  = 4'h2,
      A_DCLR  = 4'h3,
      A_IESET = 4'h4,
      A_IECLR = 4'h5,
      A_EDGE  = 4'h6,
      A_BOTH  = 4'h7,
      A_PEND  = 4'h8
   } reg_e;
endpackage

// File: rtl/flagpin_sync.sv
module flagpin_sync #(
   parameter int N      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   logic [N-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stg[s] <= '0;
               else     stg[s] <= d;
            end
         end else begin : g_rest
            always_ff @(posedge clk) begin
               if (rst) stg[s] <= '0;
               else     stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/flagpin_regs.sv
module flagpin_regs
   import flagpin_pkg::*;
#(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wen,
   input  reg_e         waddr,
   input  logic [N-1:0] wmask,
   output logic [N-1:0] dir_q,
   output logic [N-1:0] dat_q,
   output logic [N-1:0] ie_q,
   output logic [N-1:0] edg_q,
   output logic [N-1:0] both_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q  <= '0;
         dat_q  <= '0;
         ie_q   <= '0;
         edg_q  <= '0;
         both_q <= '0;
      end else if (wen) begin
         case (waddr)
            A_DIR:   dir_q  <= wmask;
            A_DSET:  dat_q  <= dat_q | wmask;
            A_DCLR:  dat_q  <= dat_q & ~wmask;
            A_IESET: ie_q   <= ie_q | wmask;
            A_IECLR: ie_q   <= ie_q & ~wmask;
            A_EDGE:  edg_q  <= wmask;
            A_BOTH:  both_q <= wmask;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/flagpin_detect.sv
module flagpin_detect #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] sense,
   input  logic [N-1:0] edg,
   input  logic [N-1:0] both,
   input  logic [N-1:0] clr,
   output logic [N-1:0] lat,
   output logic [N-1:0] pend
);
   logic [N-1:0] prev_q;
   logic [N-1:0] lat_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_pin
         logic rise, fall, hit;
         assign rise = sense[i] & ~prev_q[i];
         assign fall = ~sense[i] & prev_q[i];
         assign hit  = edg[i] & (rise | (both[i] & fall));

         always_ff @(posedge clk) begin
            if (rst) begin
               prev_q[i] <= 1'b0;
               lat_q[i]  <= 1'b0;
            end else begin
               prev_q[i] <= sense[i];
               lat_q[i]  <= (lat_q[i] | hit) & ~clr[i];
            end
         end

         assign pend[i] = edg[i] ? lat_q[i] : sense[i];
      end
   endgenerate

   assign lat = lat_q;
endmodule

// File: rtl/flagpin_bank.sv
module flagpin_bank
   import flagpin_pkg::*;
#(
   parameter int N           = 16,
   parameter int DW          = 32,
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bus_sel,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic [N-1:0]  pad_in,
   output logic [N-1:0]  pad_out,
   output logic [N-1:0]  pad_oe,
   output logic          irq
);
   generate
      if (N < 1 || N > DW) begin : g_bad_n
         $error("flagpin_bank: N must lie in 1..DW");
      end
      if (AW < REG_AW) begin : g_bad_aw
         $error("flagpin_bank: AW too small for the register map");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("flagpin_bank: at least two synchronizer stages");
      end
   endgenerate

   logic         addr_hit;
   reg_e         ra;
   logic         wen;
   logic [N-1:0] wmask;
   logic [N-1:0] dir_q, dat_q, ie_q, edg_q, both_q;
   logic [N-1:0] pad_sync, sense, clr_mask, pend, edge_lat;
   logic [N-1:0] rd_n;

   generate
      if (AW > REG_AW) begin : g_hi_dec
         assign addr_hit = (bus_addr[AW-1:REG_AW] == '0);
      end else begin : g_no_hi
         assign addr_hit = 1'b1;
      end
   endgenerate

   assign ra    = reg_e'(bus_addr[REG_AW-1:0]);
   assign wen   = bus_sel & bus_we & addr_hit;
   assign wmask = bus_wdata[N-1:0];

   flagpin_regs #(.N(N)) u_regs (
      .clk    (clk),
      .rst    (rst),
      .wen    (wen),
      .waddr  (ra),
      .wmask  (wmask),
      .dir_q  (dir_q),
      .dat_q  (dat_q),
      .ie_q   (ie_q),
      .edg_q  (edg_q),
      .both_q (both_q)
   );

   flagpin_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pad_in),
      .q   (pad_sync)
   );

   assign sense    = (dir_q & dat_q) | (~dir_q & pad_sync);
   assign clr_mask = (wen && ra == A_PEND) ? wmask : '0;

   flagpin_detect #(.N(N)) u_det (
      .clk   (clk),
      .rst   (rst),
      .sense (sense),
      .edg   (edg_q),
      .both  (both_q),
      .clr   (clr_mask),
      .lat   (edge_lat),
      .pend  (pend)
   );

   always_comb begin
      rd_n = '0;
      if (bus_sel && addr_hit) begin
         case (ra)
            A_DIR:            rd_n = dir_q;
            A_SENSE:          rd_n = sense;
            A_DSET, A_DCLR:   rd_n = dat_q;
            A_IESET, A_IECLR: rd_n = ie_q;
            A_EDGE:           rd_n = edg_q;
            A_BOTH:           rd_n = both_q;
            A_PEND:           rd_n = pend;
            default:          rd_n = '0;
         endcase
      end
      bus_rdata        = '0;
      bus_rdata[N-1:0] = rd_n;
   end

   assign pad_out = dat_q;
   assign pad_oe  = dir_q;
   assign irq     = |(pend & ie_q);
endmodule

// File: rtl/flagpin_chk.sv
module flagpin_chk
   import flagpin_pkg::*;
#(
   parameter int N  = 16,
   parameter int DW = 32,
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst,
   input logic          bus_sel,
   input logic          bus_we,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic [N-1:0]  pad_out,
   input logic [N-1:0]  pad_oe,
   input logic          irq,
   input logic [N-1:0]  lat,
   input logic [N-1:0]  ie
);
   logic wr;
   assign wr = bus_sel && bus_we;

   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (pad_oe == '0 && pad_out == '0 && !irq));

   a_r2_oe_holds: assert property (@(posedge clk) disable iff (rst)
      !(wr && bus_addr == AW'(A_DIR)) |=> $stable(pad_oe));

   a_r3_set_ors: assert property (@(posedge clk) disable iff (rst)
      (wr && bus_addr == AW'(A_DSET)) |=>
         pad_out == ($past(pad_out) | $past(bus_wdata[N-1:0])));

   a_r4_clr_masks: assert property (@(posedge clk) disable iff (rst)
      (wr && bus_addr == AW'(A_DCLR)) |=>
         pad_out == ($past(pad_out) & ~$past(bus_wdata[N-1:0])));

   a_r6_ie_set_ors: assert property (@(posedge clk) disable iff (rst)
      (wr && bus_addr == AW'(A_IESET)) |=>
         ie == ($past(ie) | $past(bus_wdata[N-1:0])));

   a_r8_latch_sticky: assert property (@(posedge clk) disable iff (rst)
      !(wr && bus_addr == AW'(A_PEND)) |=> ((lat & $past(lat)) == $past(lat)));

   a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
      (wr && bus_addr == AW'(A_PEND)) |=> ((lat & $past(bus_wdata[N-1:0])) == '0));

   a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
      (ie == '0) |-> !irq);
endmodule

bind flagpin_bank flagpin_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .irq       (irq),
   .lat       (edge_lat),
   .ie        (ie_q)
);

// File: tb/flagpin_bank_tb.sv
`timescale 1ns/100ps
module flagpin_bank_tb;
   localparam int N  = 16;
   localparam int DW = 32;
   localparam int AW = 4;
   localparam logic [3:0] W_DIR = 4'h0, W_SNS = 4'h1, W_DS = 4'h2, W_DC = 4'h3,
                          W_IS = 4'h4, W_IC = 4'h5, W_EG = 4'h6, W_BO = 4'h7,
                          W_PD = 4'h8, W_NONE = 4'hF;
   localparam logic [N-1:0] EMASK = 16'h1E01;

   typedef struct packed {
      logic [3:0]  wa;
      logic [31:0] wd;
      logic [3:0]  ra;
      logic [31:0] exp;
   } vec_t;

   localparam vec_t TBL [12] = '{
      '{W_DS,   32'h0000_00F0, W_DS,  32'h0000_00F0},  // R3
      '{W_DS,   32'h0000_0003, W_DS,  32'h0000_00F3},  // R3 zeros keep
      '{W_DC,   32'h0000_0030, W_DC,  32'h0000_00C3},  // R4
      '{W_DC,   32'h0000_0000, W_DS,  32'h0000_00C3},  // R4 zeros keep
      '{W_IS,   32'h0000_8001, W_IS,  32'h0000_8001},  // R6
      '{W_IC,   32'h0000_0001, W_IC,  32'h0000_8000},  // R6
      '{W_DIR,  32'h0000_00FF, W_DIR, 32'h0000_00FF},  // R2
      '{W_SNS,  32'h0000_FFFF, W_SNS, 32'h0000_00C3},  // R5 R13
      '{W_NONE, 32'hFFFF_FFFF, W_NONE,32'h0000_0000},  // R13
      '{W_EG,   32'hFFFF_FFFF, W_EG,  32'h0000_FFFF},  // R13 upper bits
      '{W_BO,   32'h0000_000F, W_BO,  32'h0000_000F},  // R9 config
      '{W_PD,   32'h0000_FFFF, W_PD,  32'h0000_0000}   // R10
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bus_sel = 1'b0, bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [N-1:0]  pad_in = '0;
   logic [N-1:0]  pad_out, pad_oe;
   logic          irq;
   int            n_chk = 0, n_bad = 0;
   logic [31:0]   rv;

   always #2 clk = ~clk;

   flagpin_bank #(.N(N), .DW(DW), .AW(AW)) u_dut (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #0.1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; pad_in = '0;
      waitn(3);
      rst = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      // table walk: each row writes, then reads a word back
      for (int k = 0; k < 12; k++) begin
         wr(TBL[k].wa, TBL[k].wd);
         rd(TBL[k].ra, rv);
         check(rv, TBL[k].exp, $sformatf("table row %0d", k));
      end

      // R1 reset state
      do_reset();
      for (int a = 0; a < 9; a++) begin
         rd(4'(a), rv);
         check(rv, 32'h0, $sformatf("R1 word %0d after reset", a));
      end
      check({16'h0, pad_oe}, 32'h0, "R1 pad_oe");
      check({16'h0, pad_out}, 32'h0, "R1 pad_out");
      check({31'h0, irq}, 32'h0, "R1 irq");

      // R2 direction and output pins
      wr(W_DIR, 32'h00FF);
      wr(W_DS, 32'h0055);
      check({16'h0, pad_oe}, 32'h00FF, "R2 pad_oe");
      check({16'h0, pad_out}, 32'h0055, "R2 pad_out");

      // R5 synchronizer latency, R12 output pin ignores its pad
      pad_in = 16'h0102;
      waitn(1);
      rd(W_SNS, rv);
      check(rv, 32'h0055, "R5 sense after one edge");
      waitn(1);
      rd(W_SNS, rv);
      check(rv, 32'h0155, "R5 sense after two edges");

      // R7 level and R11
      wr(W_IS, 32'h0100);
      rd(W_PD, rv);
      check(rv, 32'h0155, "R7 level pending equals sense");
      check({31'h0, irq}, 32'h1, "R11 irq with enabled level pin");
      wr(W_IC, 32'h0100);
      check({31'h0, irq}, 32'h0, "R11 irq after enable cleared");
      wr(W_IS, 32'h0100);
      pad_in[8] = 1'b0;
      waitn(3);
      rd(W_PD, rv);
      check(rv, 32'h0055, "R7 level pending follows pad low");
      check({31'h0, irq}, 32'h0, "R11 irq drops with level");
      wr(W_IC, 32'h0100);

      // edge configuration: pins 0,9,10,11,12 edge; pin 10 both
      wr(W_EG, {16'h0, EMASK});
      wr(W_BO, 32'h0400);

      // R8 rising only
      wr(W_IS, 32'h0200);
      pad_in[9] = 1'b1; waitn(4);
      rd(W_PD, rv);
      check(rv & EMASK, 32'h0200, "R8 rise latched");
      check({31'h0, irq}, 32'h1, "R11 irq from edge latch");
      pad_in[9] = 1'b0; waitn(4);
      rd(W_PD, rv);
      check(rv & EMASK, 32'h0200, "R8 latch sticky after pad falls");
      wr(W_PD, 32'h0200);
      rd(W_PD, rv);
      check(rv & EMASK, 32'h0, "R10 write-one clears latch");
      check({31'h0, irq}, 32'h0, "R11 irq after clear");
      pad_in[9] = 1'b1; waitn(4);
      wr(W_PD, 32'h0200);
      pad_in[9] = 1'b0; waitn(4);
      rd(W_PD, rv);
      check(rv & EMASK, 32'h0, "R8 falling edge ignored");
      wr(W_IC, 32'h0200);

      // R9 both edges
      pad_in[10] = 1'b1; waitn(4);
      rd(W_PD, rv);
      check(rv & EMASK, 32'h0400, "R9 rise latched");
      wr(W_PD, 32'h0400);
      pad_in[10] = 1'b0; waitn(4);
      rd(W_PD, rv);
      check(rv & EMASK, 32'h0400, "R9 fall latched");
      wr(W_PD, 32'h0400);

      // R12 output pin edges come from written data
      wr(W_DC, 32'h0001);
      waitn(2);
      rd(W_PD, rv);
      check(rv & EMASK, 32'h0, "R12 data fall ignored in rise mode");
      wr(W_DS, 32'h0001);
      waitn(1);
      rd(W_PD, rv);
      check(rv & EMASK, 32'h0001, "R12 data rise latched");
      wr(W_PD, 32'h0001);
      pad_in[0] = 1'b1; waitn(4);
      pad_in[0] = 1'b0; waitn(4);
      rd(W_PD, rv);
      check(rv & EMASK, 32'h0, "R12 output pad toggle ignored");

      // R10 clear lands in the same cycle as a new edge
      pad_in[11] = 1'b1;
      waitn(1);
      wr(W_PD, 32'h0800);
      rd(W_PD, rv);
      check(rv & EMASK, 32'h0, "R10 clear wins over coincident edge");
      waitn(4);
      rd(W_PD, rv);
      check(rv & EMASK, 32'h0, "R10 no late re-latch");
      pad_in[12] = 1'b1;
      waitn(1);
      wr(W_PD, 32'h0000);
      rd(W_PD, rv);
      check(rv & EMASK, 32'h1000, "R10 zero mask keeps coincident edge");
      wr(W_IS, 32'h1000);
      check({31'h0, irq}, 32'h1, "R11 enable on pending latch");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule